// File: doc/BRIEF.md
# Flash Page Program Buffer

This block sits behind the serial command engine of a small flash memory model and carries out the data side of the page program operation. After the engine decodes a program instruction it hands over a start address, then a stream of data bytes, and finally a commit strobe when chip select is released. The commit strobe comes with a flag that says whether a partial byte was being shifted in at that moment. The block holds a one-page buffer of 128 bytes with a valid bit for each byte. When a commit is accepted it runs a self-timed busy period and then merges only the valid bytes into the array. The merge can only clear bits, so each written byte becomes the old contents ANDed with the new data.

The same array can also be erased, either one sector or the whole array, and an erase sets every byte in its range to all ones. Program and erase durations are parameters counted in clock cycles. While the busy period runs, all new requests are ignored. When the busy period ends, the block issues a one-cycle pulse that clears the write enable latch held in the command engine. A combinational read port lets the engine, or a test, see the array contents.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy_o and wel_clr_o are 0 and every array byte reads 8'hFF.
- R2: A program stores, at each written address, the old array byte ANDed with the new data byte, so bits only go from 1 to 0.
- R3: Array bytes that received no data byte since the last accepted start keep their contents, including the other bytes of the same page.
- R4: The in-page offset starts at the low 7 bits of the start address and increments modulo 128, while the page number stays fixed. When more than 128 bytes are sent, only the last byte sent to each offset is programmed.
- R5: A commit with partial_i=1 starts no busy period and leaves the array unchanged.
- R6: An accepted commit keeps busy_o high for exactly PROG_CYCLES cycles. The array does not change until the last of those cycles, and wel_clr_o is high for exactly that one last cycle.
- R7: While busy_o is 1, the inputs start_i, byte_valid_i, commit_i and erase_i are ignored. The buffer contents and the start position are kept.
- R8: A sector erase (erase_i=1, bulk_i=0) sets every byte of the sector selected by addr_i[ADDR_W-1:SECTOR_W] to 8'hFF and leaves the other sectors unchanged. It keeps busy_o high for SECT_CYCLES cycles.
- R9: A bulk erase (erase_i=1, bulk_i=1) sets the whole array to 8'hFF. It keeps busy_o high for BULK_CYCLES cycles.
- R10: When commit_i and erase_i are both raised in the same idle cycle, the commit wins and the erase is dropped.
- R11: A commit is ignored when no data byte has been received since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the start address and clear the valid mask |
| addr_i | input | ADDR_W | Start address, or the erase address that selects the sector |
| byte_valid_i | input | 1 | A data byte is present |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Chip select released: request the program |
| partial_i | input | 1 | Bits of an incomplete byte were pending at commit |
| erase_i | input | 1 | Request an erase |
| bulk_i | input | 1 | 1 = whole array, 0 = one sector |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |
| busy_o | output | 1 | Program or erase in progress |
| wel_clr_o | output | 1 | One-cycle pulse at the end of the operation |

## Verification
A commit and an erase request can reach the block in the same idle cycle. The bench raises both strobes on one clock edge, right after a byte has been loaded into the buffer. It judges the outcome in three ways: the length of the busy period must match the program duration, the loaded byte must be merged into the array, and the sector named on addr_i must keep its contents. Requests raised during a busy period are a second kind of overlap, and they are judged by reissuing a commit afterwards. That commit must reprogram the untouched buffer and leave the array unchanged.

// File: rtl/fpp_pkg.sv
`timescale 1ns/1ps
package fpp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BULK = 2'd2
  } fpp_op_e;
endpackage

// File: rtl/fpp_page_buf.sv
`timescale 1ns/1ps
module fpp_page_buf #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PNUM_W = ADDR_W - PAGE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic [7:0]                 data_i,
  output logic [PNUM_W-1:0]          page_o,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic [PAGE_BYTES-1:0]      mask_o
);
  logic [PAGE_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      page_o <= '0;
      mask_o <= '0;
      data_o <= '0;
    end else if (start_i) begin
      off_q  <= addr_i[PAGE_W-1:0];
      page_o <= addr_i[ADDR_W-1:PAGE_W];
      mask_o <= '0;
    end else if (wr_i) begin
      data_o[off_q] <= data_i;
      mask_o[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1;  // wraps inside the page
    end
  end
endmodule

// File: rtl/fpp_timer.sv
`timescale 1ns/1ps
module fpp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fpp_array.sv
`timescale 1ns/1ps
module fpp_array #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 7,
  parameter int SECTOR_W = 8,
  localparam int WORDS      = 1 << ADDR_W,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         prog_i,
  input  logic [ADDR_W-PAGE_W-1:0]     page_i,
  input  logic [PAGE_BYTES-1:0][7:0]   pbuf_i,
  input  logic [PAGE_BYTES-1:0]        pmask_i,
  input  logic                         sect_i,
  input  logic [ADDR_W-SECTOR_W-1:0]   sect_sel_i,
  input  logic                         bulk_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [7:0]                   rd_data_o
);
  logic [WORDS-1:0][7:0] mem;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] A = ADDR_W'(g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= 8'hFF;
      else if (bulk_i || (sect_i && A[ADDR_W-1:SECTOR_W] == sect_sel_i))
        q <= 8'hFF;
      else if (prog_i && A[ADDR_W-1:PAGE_W] == page_i && pmask_i[A[PAGE_W-1:0]])
        q <= q & pbuf_i[A[PAGE_W-1:0]];  // program clears bits only
    end
    assign mem[g] = q;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_page_prog.sv
`timescale 1ns/1ps
module flash_page_prog #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 7,
  parameter int SECTOR_W    = 8,
  parameter int PROG_CYCLES = 20,
  parameter int SECT_CYCLES = 30,
  parameter int BULK_CYCLES = 40,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int MAX_A   = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES,
  localparam int MAX_CYC = (MAX_A > BULK_CYCLES) ? MAX_A : BULK_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              commit_i,
  input  logic              partial_i,
  input  logic              erase_i,
  input  logic              bulk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  import fpp_pkg::*;

  logic                          done;
  logic                          idle;
  logic                          go_prog, go_erase, load;
  logic                          buf_start, buf_wr;
  logic [CNT_W-1:0]              len;
  logic [ADDR_W-PAGE_W-1:0]      page;
  logic [PAGE_BYTES-1:0][7:0]    pdata;
  logic [PAGE_BYTES-1:0]         pmask;
  fpp_op_e                       op_q;
  logic [ADDR_W-SECTOR_W-1:0]    sect_q;

  assign idle      = !busy_o;
  // priority: commit > erase > start > byte
  assign go_prog   = idle && commit_i && !partial_i && (|pmask);
  assign go_erase  = idle && erase_i && !commit_i;
  assign load      = go_prog || go_erase;
  assign buf_start = idle && start_i && !commit_i && !erase_i;
  assign buf_wr    = idle && byte_valid_i && !start_i && !commit_i && !erase_i;

  always_comb begin
    if (go_prog)     len = CNT_W'(PROG_CYCLES);
    else if (bulk_i) len = CNT_W'(BULK_CYCLES);
    else             len = CNT_W'(SECT_CYCLES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_PROG;
      sect_q <= '0;
    end else if (load) begin
      op_q   <= go_prog ? OP_PROG : (bulk_i ? OP_BULK : OP_SECT);
      sect_q <= addr_i[ADDR_W-1:SECTOR_W];
    end
  end

  fpp_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(buf_start),
    .addr_i (addr_i),
    .wr_i   (buf_wr),
    .data_i (byte_i),
    .page_o (page),
    .data_o (pdata),
    .mask_o (pmask)
  );

  fpp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .busy_o(busy_o),
    .done_o(done)
  );

  fpp_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (done && op_q == OP_PROG),
    .page_i    (page),
    .pbuf_i    (pdata),
    .pmask_i   (pmask),
    .sect_i    (done && op_q == OP_SECT),
    .sect_sel_i(sect_q),
    .bulk_i    (done && op_q == OP_BULK),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign wel_clr_o = done;
endmodule

// File: rtl/flash_page_prog_chk.sv
`timescale 1ns/1ps
module flash_page_prog_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic              partial_i,
  input logic              erase_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              busy_o,
  input logic              wel_clr_o
);
  p_wel_inside_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> busy_o);

  p_wel_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !busy_o);

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wel_clr_o) |=> busy_o);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wel_clr_o) |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));

  p_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && partial_i && !busy_o) |=> !busy_o);

  p_erase_go_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && !commit_i && !busy_o) |=> busy_o);
endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .commit_i (commit_i),
  .partial_i(partial_i),
  .erase_i  (erase_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .busy_o   (busy_o),
  .wel_clr_o(wel_clr_o)
);

// File: tb/flash_page_prog_bench.sv
`timescale 1ns/1ps
module flash_page_prog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 7;
  localparam int SECTOR_W = 8;
  localparam int PROG_C = 20;
  localparam int SECT_C = 30;
  localparam int BULK_C = 40;
  localparam int WORDS = 1 << ADDR_W;

  typedef struct packed {
    logic [9:0] addr;
    logic [7:0] data;
    logic [7:0] expv;
  } vec_t;

  // single-byte programs on a fresh array: R2 AND merge
  localparam vec_t VEC [6] = '{
    '{10'h005, 8'hA5, 8'hA5},
    '{10'h005, 8'h3C, 8'h24},
    '{10'h3FF, 8'h0F, 8'h0F},
    '{10'h080, 8'hF0, 8'hF0},
    '{10'h080, 8'h0F, 8'h00},
    '{10'h17F, 8'hFF, 8'hFF}
  };

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, byte_valid_i = 0, commit_i = 0, partial_i = 0, erase_i = 0, bulk_i = 0;
  logic [ADDR_W-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0] byte_i = '0, rd_data_o;
  logic busy_o, wel_clr_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_prog #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
    .PROG_CYCLES(PROG_C), .SECT_CYCLES(SECT_C), .BULK_CYCLES(BULK_C)) u_flash_page_prog (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .commit_i(commit_i),
    .partial_i(partial_i), .erase_i(erase_i), .bulk_i(bulk_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .wel_clr_o(wel_clr_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic do_start(input int a);
    start_i = 1; addr_i = ADDR_W'(a);
    @(negedge clk); start_i = 0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_valid_i = 1; byte_i = b;
    @(negedge clk); byte_valid_i = 0;
  endtask

  task automatic wait_done(output int bc, output int wc);
    bc = 0; wc = 0;
    while (busy_o) begin
      bc++;
      if (wel_clr_o) wc++;
      @(negedge clk);
    end
  endtask

  task automatic commit(input bit p, output int bc, output int wc);
    commit_i = 1; partial_i = p;
    @(negedge clk); commit_i = 0; partial_i = 0;
    wait_done(bc, wc);
  endtask

  task automatic erase(input bit blk, input int a, output int bc, output int wc);
    erase_i = 1; bulk_i = blk; addr_i = ADDR_W'(a);
    @(negedge clk); erase_i = 0; bulk_i = 0;
    wait_done(bc, wc);
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    logic [7:0] got = '0;
    for (int i = 0; i < WORDS; i++) begin
      rd_addr_i = ADDR_W'(i); #1;
      if (rd_data_o !== mdl[i]) begin
        bad++;
        if (first < 0) begin first = i; got = rd_data_o; end
      end
    end
    chk(bad == 0, req, $sformatf("array (first bad addr %0h)", first), got,
        first < 0 ? 0 : mdl[first]);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    int bc, wc;
    logic [7:0] pb [128];
    bit pm [128];
    for (int i = 0; i < WORDS; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    chk(wel_clr_o == 0, "R1", "wel_clr after reset", wel_clr_o, 0);
    check_mem("R1");

    // R2 table of single-byte programs
    foreach (VEC[v]) begin
      do_start(VEC[v].addr);
      put(VEC[v].data);
      commit(0, bc, wc);
      mdl[VEC[v].addr] = mdl[VEC[v].addr] & VEC[v].data;
      rd_addr_i = VEC[v].addr; #1;
      chk(rd_data_o == VEC[v].expv, "R2", $sformatf("vector %0d", v), rd_data_o, VEC[v].expv);
      @(negedge clk);
    end

    // R3 partial page; R6 timing and wel pulse
    do_start(10'h10A);
    put(8'h81); put(8'h42); put(8'h18);
    commit(0, bc, wc);
    chk(bc == PROG_C, "R6", "program busy cycles", bc, PROG_C);
    chk(wc == 1, "R6", "wel_clr pulse count", wc, 1);
    mdl[10'h10A] &= 8'h81; mdl[10'h10B] &= 8'h42; mdl[10'h10C] &= 8'h18;
    check_mem("R3");

    // R4 wrap: start at offset 126 of page 3, send 130 bytes
    for (int o = 0; o < 128; o++) pm[o] = 0;
    do_start(10'h1FE);
    for (int k = 0; k < 130; k++) begin
      put(8'(k) ^ 8'h5A);
      pb[(126 + k) % 128] = 8'(k) ^ 8'h5A;
      pm[(126 + k) % 128] = 1;
    end
    commit(0, bc, wc);
    for (int o = 0; o < 128; o++) if (pm[o]) mdl[10'h180 + o] &= pb[o];
    rd_addr_i = 10'h1FE; #1;
    chk(rd_data_o == (8'd128 ^ 8'h5A), "R4", "offset 126 holds last byte", rd_data_o, 8'd128 ^ 8'h5A);
    @(negedge clk);
    check_mem("R4");

    // R5 partial final byte aborts
    do_start(10'h300);
    put(8'h00);
    commit(1, bc, wc);
    chk(bc == 0, "R5", "busy cycles after partial commit", bc, 0);
    check_mem("R5");

    // R11 commit with no bytes
    do_start(10'h300);
    commit(0, bc, wc);
    chk(bc == 0, "R11", "busy cycles with empty buffer", bc, 0);

    // R7 requests during busy are ignored
    do_start(10'h200);
    put(8'h55);
    commit_i = 1; @(negedge clk); commit_i = 0;
    erase_i = 1; bulk_i = 1; @(negedge clk); erase_i = 0; bulk_i = 0;
    start_i = 1; addr_i = 10'h000; @(negedge clk); start_i = 0;
    byte_valid_i = 1; byte_i = 8'h00; @(negedge clk); byte_valid_i = 0;
    commit_i = 1; @(negedge clk); commit_i = 0;
    wait_done(bc, wc);
    chk(bc == PROG_C - 4, "R7", "remaining busy cycles", bc, PROG_C - 4);
    @(negedge clk);
    chk(busy_o == 0, "R7", "no second operation", busy_o, 0);
    mdl[10'h200] &= 8'h55;
    check_mem("R7");
    commit(0, bc, wc);
    chk(bc == PROG_C, "R7", "buffer kept, recommit busy cycles", bc, PROG_C);
    check_mem("R7");

    // R10 commit and erase in the same cycle
    do_start(10'h000);
    put(8'h77);
    commit_i = 1; erase_i = 1; addr_i = 10'h000;
    @(negedge clk); commit_i = 0; erase_i = 0;
    wait_done(bc, wc);
    chk(bc == PROG_C, "R10", "busy cycles of simultaneous request", bc, PROG_C);
    mdl[10'h000] &= 8'h77;
    check_mem("R10");

    // R8 sector erase of sector 1
    erase(0, 10'h150, bc, wc);
    chk(bc == SECT_C, "R8", "sector erase busy cycles", bc, SECT_C);
    chk(wc == 1, "R8", "wel_clr pulse count", wc, 1);
    for (int i = 10'h100; i < 10'h200; i++) mdl[i] = 8'hFF;
    check_mem("R8");

    // R9 bulk erase
    erase(1, 10'h000, bc, wc);
    chk(bc == BULK_C, "R9", "bulk erase busy cycles", bc, BULK_C);
    for (int i = 0; i < WORDS; i++) mdl[i] = 8'hFF;
    check_mem("R9");

    finish_run();
  end
endmodule